// File: doc/BRIEF.md
# SD Host Ping-Pong Block Buffer

This block sits between a processor's 32-bit buffer data port and the byte streams of an SD card data path. It holds two storage banks, each large enough for the largest block, and uses them in turn: while one bank is being filled, the other is being emptied. In the card-bound direction the processor fills a bank one word at a time, and a byte stream toward the serializer drains it. In the host-bound direction a byte stream from the deserializer fills a bank, and the processor drains it word by word.

Access is handed out one whole block at a time. A sticky write-ready or read-ready status bit tells the processor that a complete block may be written or read. The processor clears a bit by writing 1 to it. A transfer is armed by a start pulse, which captures the direction, the block size and the block count. A remaining-block counter runs down as blocks finish on the card side, and a one-cycle completion pulse marks the end. When both banks hold unread blocks during a read, the block raises a stop request so the card side can apply read wait or halt the card clock.

Top module: `sd_pingpong_buf`

## Requirements
- R1: While reset is applied and after it is released, wr_ready, rd_ready, tx_valid, rx_ready, card_stop and xfer_done are 0 and blocks_left is 0.
- R2: In the card-bound direction (xfer_dir=0), wr_ready is raised only when the bank the processor fills next is empty and fewer blocks have been granted than were programmed. It is never raised while both banks hold unsent blocks.
- R3: tx_valid is high only while a complete block is stored. Bytes leave in the order they were written, with bits 7:0 of each written word going first.
- R4: While one block is being sent toward the card, the grant for the next block (wr_ready) can already be raised so that the other bank is filled at the same time.
- R5: In the host-bound direction (xfer_dir=1), rx_ready is high only when the receiving bank is not full and blocks_left is nonzero.
- R6: rd_ready is raised when a complete received block is stored. cpu_rdata shows the next word of that block without a read strobe, bits 7:0 holding the earliest received byte, and each cpu_rd advances by one word.
- R7: card_stop is high exactly when, in the host-bound direction, both banks hold unread blocks and blocks_left is nonzero. rx_ready is never high at the same time.
- R8: A cycle with sts_clr_wr=1 clears wr_ready when sts_clr_wdata bit 0 is 1, and clears rd_ready when bit 1 is 1, at the next clock edge. A cleared bit rises again on the edge after the next block becomes available.
- R9: The block size is 4 to 512 bytes in multiples of 4. Each grant covers exactly block-size bytes, which is block-size/4 processor words.
- R10: blocks_left is loaded with the block count at start and drops by one when each block finishes on the card side. xfer_done pulses for one cycle when it reaches 0, and no further write grant follows.
- R11: A processor write without an outstanding write grant, or a processor read without an outstanding read grant, is discarded and moves no pointer.
- R12: A start with block count 0 produces no ready bit, no tx_valid, no rx_ready and no xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Pulse that arms a transfer and empties both banks |
| xfer_dir | input | 1 | 0 = toward card, 1 = from card; captured at start |
| blk_size | input | 10 | Block length in bytes, captured at start |
| blk_count | input | 16 | Number of blocks, captured at start |
| cpu_wr | input | 1 | Processor data port write strobe |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rd | input | 1 | Processor data port read strobe |
| cpu_rdata | output | 32 | Current read word (show-ahead) |
| sts_clr_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_clr_wdata | input | 2 | Bit 0 clears wr_ready, bit 1 clears rd_ready |
| wr_ready | output | 1 | Sticky write-ready status bit |
| rd_ready | output | 1 | Sticky read-ready status bit |
| tx_valid | output | 1 | Byte available toward serializer |
| tx_data | output | 8 | Byte toward serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Byte offered by deserializer |
| rx_data | input | 8 | Byte from deserializer |
| rx_ready | output | 1 | Buffer accepts the offered byte |
| card_stop | output | 1 | Request for read wait or clock stop |
| blocks_left | output | 16 | Blocks not yet finished on the card side |
| xfer_done | output | 1 | One-cycle pulse when the last block finishes |

## Verification
A wrong bank-full flag or bank select shows at the ports within one block time. Bytes then leave out of order, a grant arrives while both banks are occupied, or card_stop and rx_ready disagree, and the bench watches each of these from the first affected byte. A wrong pointer wrap shows as a corrupted byte at the next block boundary. A wrong grant or block counter shows as one grant too many or too few, a missing completion pulse, or blocks_left not reaching zero at the end of each transfer. The clear-then-reassert timing of the status bits is checked cycle by cycle, so a set/clear priority error is seen on the cycle it happens.

// File: rtl/sd_pp_pkg.sv
package sd_pp_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
  localparam int unsigned STS_WR_BIT = 0;
  localparam int unsigned STS_RD_BIT = 1;
  localparam int unsigned STS_BITS   = 2;

  typedef enum logic {
    DIR_TO_CARD   = 1'b0,
    DIR_FROM_CARD = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/sd_pp_rst_sync.sv
module sd_pp_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/sd_pp_store.sv
module sd_pp_store #(
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned IW        = $clog2(BUF_BYTES)
) (
  input  logic                         clk,
  input  logic                         word_we,
  input  logic [sd_pp_pkg::WORD_W-1:0] word_wdata,
  input  logic                         byte_we,
  input  logic [7:0]                   byte_wdata,
  input  logic                         wsel,
  input  logic [IW-1:0]                wptr,
  input  logic                         rsel,
  input  logic [IW-1:0]                rptr,
  output logic [sd_pp_pkg::WORD_W-1:0] word_rdata,
  output logic [7:0]                   byte_rdata
);
  import sd_pp_pkg::*;
  localparam int unsigned LW = $clog2(WORD_BYTES);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0]        mem [BUF_BYTES];
    logic [WORD_W-1:0] rw;
    logic [7:0]        rb;
    logic              hit;

    assign hit = (wsel == (b != 0));

    always_ff @(posedge clk) begin
      if (word_we && hit) begin
        for (int j = 0; j < int'(WORD_BYTES); j++)
          mem[{wptr[IW-1:LW], LW'(j)}] <= word_wdata[8*j +: 8];
      end
      if (byte_we && hit) mem[wptr] <= byte_wdata;
    end

    always_comb begin
      for (int j = 0; j < int'(WORD_BYTES); j++)
        rw[8*j +: 8] = mem[{rptr[IW-1:LW], LW'(j)}];
    end
    assign rb = mem[rptr];
  end

  assign word_rdata = rsel ? g_bank[1].rw : g_bank[0].rw;
  assign byte_rdata = rsel ? g_bank[1].rb : g_bank[0].rb;
endmodule

// File: rtl/sd_pp_w1c.sv
module sd_pp_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_n;

  always_comb begin
    q_n = q;
    if (start)    q_n = 1'b0;
    else if (set) q_n = 1'b1;
    else if (clr) q_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_n;
  end
endmodule

// File: rtl/sd_pp_ctrl.sv
module sd_pp_ctrl #(
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SZ_W      = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [SZ_W-1:0]  blk_size,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             tx_ready,
  input  logic             rx_valid,
  output logic             tx_valid,
  output logic             rx_ready,
  output logic             card_stop,
  output logic [CNT_W-1:0] blocks_left,
  output logic             xfer_done,
  output logic             grant_wr,
  output logic             grant_rd,
  output logic             word_we,
  output logic             byte_we,
  output logic             psel,
  output logic [SZ_W-1:0]  pptr,
  output logic             csel,
  output logic [SZ_W-1:0]  cptr
);
  import sd_pp_pkg::*;

  logic             mode_q, mode_n;
  logic [SZ_W-1:0]  size_q, size_n;
  logic [1:0]       full_q, full_n;
  logic             psel_q, psel_n, csel_q, csel_n;
  logic [SZ_W-1:0]  pptr_q, pptr_n, cptr_q, cptr_n;
  logic             pgnt_q, pgnt_n, cgnt_q, cgnt_n;
  logic [CNT_W-1:0] gleft_q, gleft_n, bleft_q, bleft_n;
  logic             done_q, done_n;

  logic             rd_word, rd_byte, push, pop, p_last, c_last, card_blk;
  logic [SZ_W-1:0]  pstep, cstep;

  assign tx_valid  = (mode_q == DIR_TO_CARD) && full_q[csel_q];
  assign rx_ready  = (mode_q == DIR_FROM_CARD) && !full_q[psel_q] && (bleft_q != '0);
  assign card_stop = (mode_q == DIR_FROM_CARD) && (&full_q) && (bleft_q != '0);
  assign grant_wr  = (mode_q == DIR_TO_CARD) && !full_q[psel_q] && !pgnt_q && (gleft_q != '0);
  assign grant_rd  = (mode_q == DIR_FROM_CARD) && full_q[csel_q] && !cgnt_q;

  assign word_we = (mode_q == DIR_TO_CARD) && pgnt_q && cpu_wr && !start;
  assign byte_we = rx_valid && rx_ready && !start;
  assign rd_word = (mode_q == DIR_FROM_CARD) && cgnt_q && cpu_rd && !start;
  assign rd_byte = tx_valid && tx_ready && !start;
  assign push    = word_we || byte_we;
  assign pop     = rd_word || rd_byte;

  assign pstep    = (mode_q == DIR_FROM_CARD) ? SZ_W'(1) : SZ_W'(WORD_BYTES);
  assign cstep    = (mode_q == DIR_FROM_CARD) ? SZ_W'(WORD_BYTES) : SZ_W'(1);
  assign p_last   = push && ((pptr_q + pstep) == size_q);
  assign c_last   = pop && ((cptr_q + cstep) == size_q);
  assign card_blk = (mode_q == DIR_FROM_CARD) ? p_last : c_last;

  always_comb begin
    mode_n  = mode_q;  size_n  = size_q;  full_n  = full_q;
    psel_n  = psel_q;  csel_n  = csel_q;  pptr_n  = pptr_q;
    cptr_n  = cptr_q;  pgnt_n  = pgnt_q;  cgnt_n  = cgnt_q;
    gleft_n = gleft_q; bleft_n = bleft_q;
    if (start) begin
      mode_n  = dir;
      size_n  = blk_size;
      full_n  = 2'b00;
      psel_n  = 1'b0;
      csel_n  = 1'b0;
      pptr_n  = '0;
      cptr_n  = '0;
      pgnt_n  = 1'b0;
      cgnt_n  = 1'b0;
      gleft_n = blk_count;
      bleft_n = blk_count;
    end else begin
      if (push) begin
        pptr_n = p_last ? '0 : pptr_q + pstep;
        if (p_last) begin
          full_n[psel_q] = 1'b1;
          psel_n         = ~psel_q;
          pgnt_n         = 1'b0;
        end
      end
      if (pop) begin
        cptr_n = c_last ? '0 : cptr_q + cstep;
        if (c_last) begin
          full_n[csel_q] = 1'b0;
          csel_n         = ~csel_q;
          cgnt_n         = 1'b0;
        end
      end
      if (grant_wr) begin
        pgnt_n  = 1'b1;
        gleft_n = gleft_q - 1'b1;
      end
      if (grant_rd) cgnt_n = 1'b1;
      if (card_blk) bleft_n = bleft_q - 1'b1;
    end
  end

  assign done_n = !start && card_blk && (bleft_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= DIR_TO_CARD; size_q  <= '0;   full_q  <= 2'b00;
      psel_q  <= 1'b0;        csel_q  <= 1'b0; pptr_q  <= '0;
      cptr_q  <= '0;          pgnt_q  <= 1'b0; cgnt_q  <= 1'b0;
      gleft_q <= '0;          bleft_q <= '0;   done_q  <= 1'b0;
    end else begin
      mode_q  <= mode_n;  size_q  <= size_n;  full_q  <= full_n;
      psel_q  <= psel_n;  csel_q  <= csel_n;  pptr_q  <= pptr_n;
      cptr_q  <= cptr_n;  pgnt_q  <= pgnt_n;  cgnt_q  <= cgnt_n;
      gleft_q <= gleft_n; bleft_q <= bleft_n; done_q  <= done_n;
    end
  end

  assign blocks_left = bleft_q;
  assign xfer_done   = done_q;
  assign psel        = psel_q;
  assign csel        = csel_q;
  assign pptr        = pptr_q;
  assign cptr        = cptr_q;

  // An outstanding write grant always points at an empty bank
  assert_grant_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgnt_q |-> !full_q[psel_q]);

  // Stop request and byte acceptance never overlap
  assert_stop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_stop |-> !rx_ready);

  // Producer never writes past the programmed block length
  assert_push_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (pptr_q < size_q));

  // Counter stays at zero until a new start
  assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bleft_q == '0 && !start) |=> (bleft_q == '0));

  // Completion pulse only once every block has finished
  assert_done_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (bleft_q == '0));
endmodule

// File: rtl/sd_pingpong_buf.sv
module sd_pingpong_buf #(
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SZ_W      = $clog2(BUF_BYTES) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer_start,
  input  logic                         xfer_dir,
  input  logic [SZ_W-1:0]              blk_size,
  input  logic [CNT_W-1:0]             blk_count,
  input  logic                         cpu_wr,
  input  logic [sd_pp_pkg::WORD_W-1:0] cpu_wdata,
  input  logic                         cpu_rd,
  output logic [sd_pp_pkg::WORD_W-1:0] cpu_rdata,
  input  logic                         sts_clr_wr,
  input  logic [sd_pp_pkg::STS_BITS-1:0] sts_clr_wdata,
  output logic                         wr_ready,
  output logic                         rd_ready,
  output logic                         tx_valid,
  output logic [7:0]                   tx_data,
  input  logic                         tx_ready,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_data,
  output logic                         rx_ready,
  output logic                         card_stop,
  output logic [CNT_W-1:0]             blocks_left,
  output logic                         xfer_done
);
  import sd_pp_pkg::*;
  localparam int unsigned IW = SZ_W - 1;

  logic            rst_n_s;
  logic            grant_wr, grant_rd, word_we, byte_we, psel, csel;
  logic [SZ_W-1:0] pptr, cptr;
  logic [STS_BITS-1:0] sts_set, sts_q;

  sd_pp_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  sd_pp_ctrl #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .SZ_W(SZ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(xfer_start), .dir(xfer_dir),
    .blk_size(blk_size), .blk_count(blk_count), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .tx_valid(tx_valid),
    .rx_ready(rx_ready), .card_stop(card_stop), .blocks_left(blocks_left),
    .xfer_done(xfer_done), .grant_wr(grant_wr), .grant_rd(grant_rd),
    .word_we(word_we), .byte_we(byte_we), .psel(psel), .pptr(pptr),
    .csel(csel), .cptr(cptr)
  );

  sd_pp_store #(.BUF_BYTES(BUF_BYTES), .IW(IW)) u_store (
    .clk(clk), .word_we(word_we), .word_wdata(cpu_wdata),
    .byte_we(byte_we), .byte_wdata(rx_data), .wsel(psel), .wptr(pptr[IW-1:0]),
    .rsel(csel), .rptr(cptr[IW-1:0]), .word_rdata(cpu_rdata), .byte_rdata(tx_data)
  );

  assign sts_set[STS_WR_BIT] = grant_wr;
  assign sts_set[STS_RD_BIT] = grant_rd;

  for (genvar g = 0; g < int'(STS_BITS); g++) begin : g_sts
    sd_pp_w1c u_bit (
      .clk(clk), .rst_n(rst_n_s), .start(xfer_start), .set(sts_set[g]),
      .clr(sts_clr_wr && sts_clr_wdata[g]), .q(sts_q[g])
    );
  end

  assign wr_ready = sts_q[STS_WR_BIT];
  assign rd_ready = sts_q[STS_RD_BIT];

  // Write-one-to-clear takes effect at the next edge when no new grant competes
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sts_clr_wr && sts_clr_wdata[STS_WR_BIT] && !xfer_start && !grant_wr) |=> !wr_ready);
endmodule

// File: tb/sim_sd_pingpong_buf.sv
module sim_sd_pingpong_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0, xfer_dir = 1'b0;
  logic [9:0]  blk_size = '0;
  logic [15:0] blk_count = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        sts_clr_wr = 1'b0;
  logic [1:0]  sts_clr_wdata = '0;
  logic        wr_ready, rd_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  logic        rx_valid = 1'b0, rx_ready, card_stop, xfer_done;
  logic [15:0] blocks_left;

  int errors = 0, checks = 0, done_cnt = 0;
  int bad = 0, overlap = 0, clash = 0;

  sd_pingpong_buf u0 (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (xfer_done === 1'b1) done_cnt++;

  typedef struct packed {
    logic       rd;
    logic [9:0] size;
    logic [7:0] count;
    logic [7:0] seed;
    logic       thr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'd16,  8'd3, 8'h11, 1'b1},
    '{1'b1, 10'd16,  8'd3, 8'h22, 1'b1},
    '{1'b0, 10'd4,   8'd2, 8'h33, 1'b0},
    '{1'b1, 10'd512, 8'd2, 8'h44, 1'b0},
    '{1'b0, 10'd512, 8'd1, 8'h55, 1'b1},
    '{1'b1, 10'd4,   8'd4, 8'h66, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(input logic [7:0] seed, input int idx, input int size);
    int k, i;
    k = idx / size;
    i = idx % size;
    return 8'(int'(seed) + k * 37 + i * 5);
  endfunction

  function automatic logic [31:0] ew(input logic [7:0] seed, input int idx, input int size);
    return {eb(seed, idx + 3, size), eb(seed, idx + 2, size), eb(seed, idx + 1, size), eb(seed, idx, size)};
  endfunction

  task automatic do_start(input logic d, input int size, input int count);
    @(negedge clk);
    xfer_start = 1'b1; xfer_dir = d; blk_size = 10'(size); blk_count = 16'(count);
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic clear_sts(input logic [1:0] m);
    @(negedge clk); sts_clr_wr = 1'b1; sts_clr_wdata = m;
    @(negedge clk); sts_clr_wr = 1'b0; sts_clr_wdata = '0;
  endtask

  task automatic wait_bit(input bit rd_side);
    do @(negedge clk); while ((rd_side ? rd_ready : wr_ready) !== 1'b1);
  endtask

  task automatic cpu_write_block(input logic [7:0] seed, input int blk, input int size);
    for (int w = 0; w < size / 4; w++) begin
      if (w > 0) @(negedge clk);
      cpu_wr = 1'b1; cpu_wdata = ew(seed, blk * size + 4 * w, size);
    end
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read_block(input logic [7:0] seed, input int blk, input int size);
    for (int w = 0; w < size / 4; w++) begin
      if (w > 0) @(negedge clk);
      #1;
      if (cpu_rdata !== ew(seed, blk * size + 4 * w, size)) bad++;
      cpu_rd = 1'b1;
    end
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic tx_take(input int n, input logic [7:0] seed, input int size, input int base, input bit thr);
    int idx = 0, c = 0;
    while (idx < n) begin
      @(negedge clk);
      tx_ready = !thr || (c % 3 != 2);
      c++;
      #1;
      if (wr_ready && tx_valid) overlap++;
      if (tx_valid && tx_ready) begin
        if (tx_data !== eb(seed, base + idx, size)) bad++;
        idx++;
      end
    end
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rx_give(input int n, input logic [7:0] seed, input int size, input int base, input bit thr);
    int idx = 0, c = 0;
    while (idx < n) begin
      @(negedge clk);
      rx_valid = !thr || (c % 2 == 0);
      rx_data = eb(seed, base + idx, size);
      c++;
      #1;
      if (card_stop && rx_ready) clash++;
      if (rx_valid && rx_ready) idx++;
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int size = int'(v.size), count = int'(v.count), d0 = done_cnt;
    bad = 0; overlap = 0; clash = 0;
    do_start(v.rd, size, count);
    if (!v.rd) begin
      fork
        for (int k = 0; k < count; k++) begin
          wait_bit(1'b0); clear_sts(2'b01); cpu_write_block(v.seed, k, size);
        end
        tx_take(size * count, v.seed, size, 0, v.thr);
      join
      check(bad == 0, "R3 R9 card-bound byte order", bad, 0);
      if (count >= 2) check(overlap > 0, "R4 next grant during send", overlap, 1);
    end else begin
      fork
        for (int k = 0; k < count; k++) begin
          wait_bit(1'b1); clear_sts(2'b10); cpu_read_block(v.seed, k, size);
        end
        rx_give(size * count, v.seed, size, 0, v.thr);
      join
      check(bad == 0, "R6 R9 host-bound word data", bad, 0);
      check(clash == 0, "R7 stop with accept", clash, 0);
    end
    repeat (3) @(negedge clk);
    check(blocks_left == 0, "R10 blocks_left end", blocks_left, 0);
    check(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    #1;
    // R1: values during reset
    check({wr_ready, rd_ready, tx_valid, rx_ready, card_stop, xfer_done} == 6'b0 && blocks_left == 0,
          "R1 during reset", {wr_ready, rd_ready, tx_valid, rx_ready, card_stop, xfer_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({wr_ready, rd_ready, tx_valid, rx_ready, card_stop, xfer_done} == 6'b0 && blocks_left == 0,
          "R1 after reset", {wr_ready, rd_ready, tx_valid, rx_ready, card_stop, xfer_done}, 0);

    // R12: zero block count
    d0 = done_cnt;
    do_start(1'b0, 8, 0);
    repeat (5) @(negedge clk);
    check(!wr_ready && !tx_valid && blocks_left == 0, "R12 write count zero", {wr_ready, tx_valid}, 0);
    do_start(1'b1, 8, 0);
    repeat (5) @(negedge clk);
    check(!rd_ready && !rx_ready && done_cnt == d0, "R12 read count zero", {rd_ready, rx_ready}, 0);

    // Table of transfers
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R2 R8 R11 R10: directed card-bound sequence, size 8, three blocks, serializer stalled
    bad = 0; d0 = done_cnt;
    tx_ready = 1'b0;
    do_start(1'b0, 8, 3);
    repeat (3) @(negedge clk);
    check(wr_ready === 1'b1, "R2 first grant", wr_ready, 1);
    check(blocks_left == 3, "R10 count loaded", blocks_left, 3);
    clear_sts(2'b01);
    check(wr_ready === 1'b0, "R8 clear wr_ready", wr_ready, 0);
    cpu_write_block(8'h40, 0, 8);
    check(wr_ready === 1'b0, "R8 not yet reasserted", wr_ready, 0);
    @(negedge clk);
    check(wr_ready === 1'b1, "R8 reassert next clock", wr_ready, 1);
    clear_sts(2'b01);
    cpu_write_block(8'h40, 1, 8);
    repeat (4) @(negedge clk);
    check(wr_ready === 1'b0 && tx_valid === 1'b1, "R2 no grant both full", {wr_ready, tx_valid}, 2'b01);
    // R11: writes without a grant are discarded
    for (int w = 0; w < 2; w++) begin
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 32'hDEADBEEF;
    end
    @(negedge clk); cpu_wr = 1'b0;
    tx_take(8, 8'h40, 8, 0, 1'b0);
    repeat (2) @(negedge clk);
    check(wr_ready === 1'b1, "R2 grant after bank drained", wr_ready, 1);
    clear_sts(2'b01);
    cpu_write_block(8'h40, 2, 8);
    tx_take(16, 8'h40, 8, 8, 1'b0);
    check(bad == 0, "R11 R3 stream excludes ungranted writes", bad, 0);
    repeat (4) @(negedge clk);
    check(!wr_ready && !tx_valid && blocks_left == 0, "R10 no grant after count", {wr_ready, tx_valid}, 0);
    check(done_cnt - d0 == 1, "R10 done pulse directed", done_cnt - d0, 1);

    // R7 R5 R6 R11: host-bound with processor idle, size 8, three blocks
    bad = 0; clash = 0; d0 = done_cnt;
    do_start(1'b1, 8, 3);
    for (int w = 0; w < 2; w++) begin
      @(negedge clk); cpu_rd = 1'b1;
    end
    @(negedge clk); cpu_rd = 1'b0;
    check(rx_ready === 1'b1, "R5 accepts when empty", rx_ready, 1);
    rx_give(16, 8'h70, 8, 0, 1'b0);
    check(card_stop === 1'b1 && rx_ready === 1'b0, "R7 stop when both full", {card_stop, rx_ready}, 2'b10);
    check(rd_ready === 1'b1, "R6 read grant", rd_ready, 1);
    clear_sts(2'b10);
    cpu_read_block(8'h70, 0, 8);
    check(card_stop === 1'b0 && rx_ready === 1'b1, "R7 stop released", {card_stop, rx_ready}, 2'b01);
    rx_give(8, 8'h70, 8, 16, 1'b0);
    for (int k = 1; k < 3; k++) begin
      wait_bit(1'b1); clear_sts(2'b10); cpu_read_block(8'h70, k, 8);
    end
    check(bad == 0, "R11 R6 reads without grant discarded", bad, 0);
    repeat (3) @(negedge clk);
    check(rx_ready === 1'b0 && blocks_left == 0, "R5 no accept after count", {rx_ready, blocks_left}, 0);
    check(done_cnt - d0 == 1 && clash == 0, "R10 R7 host-bound done", done_cnt - d0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule